// File: doc/BRIEF.md
# Time-Aligned Periodic Pulse Generator

This block drives an output pin with a square wave whose edges are locked to the chip's free-running system time rather than to a count of clock cycles. Software programs a 64-bit first-edge time and a 64-bit spacing, both in the raw fixed-point units of the time bus. For a one-pulse-per-second output, the spacing is one second scaled into those units. Software then enables the generator. Each time the system time reaches the pending target, the generated level flips and the target moves forward by one spacing. An interrupt pulse can mark every flip.

Two start modes exist. In aligned mode the first flip waits for the programmed target, which software has placed on a whole-second boundary. In free mode the first target is taken from the time of enabling plus one spacing. A small pin stage decides whether the pin is driven at all, and whether it carries the generated level or a fixed software level. Because the comparison is "greater than or equal", a time bus that steps by more than one unit, or that jumps forward, never skips an edge. Missed edges are caught up one per cycle.

Top module: `pps_pulse_gen`

## Requirements
- R1: After reset, pin_out, pin_oe and irq are 0, and every register reads as zero in effect: generator off, spacing 0, target 0, pin not driven.
- R2: A register write happens on a rising edge with reg_wr high. Address 0 is control (bit0 run, bit1 aligned start, bit2 interrupt enable). Addresses 1 and 2 are the spacing low and high words. Addresses 3 and 4 are the target low and high words. Address 5 is pin setup (bit0 drive, bit1 route to generator, bit2 fixed level). Writes to addresses 6 and 7 change nothing.
- R3: With run and aligned start set, the generated level flips on the first rising edge at which sys_time >= target (unsigned compare). The new level is visible after that edge.
- R4: Every flip moves the target forward by the spacing, so the next flip comes at the first edge where sys_time >= old target + spacing.
- R5: When sys_time is ahead of the target by several spacings, the level flips on every consecutive edge until the target exceeds sys_time.
- R6: With run set and aligned start clear, the first cycle after run rises loads the target with sys_time + spacing and does not flip, even when the old target has already passed.
- R7: Writing control with run = 0 stops all flips. The generated level is 0 from the second rising edge after the write onward, and later target crossings cause no flip and no interrupt.
- R8: irq is high for exactly the one cycle that follows each flip when interrupt enable is set, and it stays 0 when interrupt enable is clear.
- R9: pin_oe equals the drive bit. pin_out equals the generated level when the route bit is 1, and equals the fixed-level bit when the route bit is 0.
- R10: A software write to a target word in the same cycle as a flip wins over the hardware advance. The written word takes the written value and the other word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | System time in raw fixed-point units |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | One-cycle pulse per generated flip |

## Verification
A corrupted target or a wrong spacing shows on pin_out as a flip one or more cycles early or late. It shows at the first crossing after the fault, and the bench compares every cycle against a closed-form count of crossed targets. A stuck or mis-cleared level shows as the wrong pin phase on the very next sample. A broken start strobe or write priority shows within a few cycles, as a spurious flip at enable time or a flip at the stale advanced target. Interrupt faults appear as a missing or extra irq cycle next to a flip.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int unsigned STAMP_W = 64;

  typedef logic [STAMP_W-1:0] stamp_t;

  // control word, bit0 upward: run, aligned start, interrupt enable
  typedef struct packed {
    logic irq_en;
    logic align;
    logic run;
  } ctrl_t;

  // pin setup, bit0 upward: drive, route to generator, fixed level
  typedef struct packed {
    logic fixed_lvl;
    logic route;
    logic drive;
  } pincfg_t;

  function automatic logic time_reached(stamp_t now, stamp_t tgt);
    return now >= tgt;
  endfunction

  function automatic stamp_t advance(stamp_t tgt, stamp_t step);
    return tgt + step;
  endfunction

endpackage

// File: rtl/pps_regs.sv
module pps_regs
  import pps_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [REG_W-1:0]                  wdata,
  output ctrl_t                             ctrl,
  output stamp_t                            period,
  output pincfg_t                           pincfg,
  output logic [STAMP_W/REG_W-1:0]          tgt_wr,
  output logic [REG_W-1:0]                  tgt_data
);

  localparam int unsigned NW     = STAMP_W / REG_W;
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_PER  = 1;
  localparam int unsigned A_TGT  = A_PER + NW;
  localparam int unsigned A_PIN  = A_TGT + NW;
  localparam int unsigned CW     = $bits(ctrl_t);
  localparam int unsigned PW     = $bits(pincfg_t);

  logic ctrl_hit, pin_hit;
  assign ctrl_hit = wr && (addr == ADDR_W'(A_CTRL));
  assign pin_hit  = wr && (addr == ADDR_W'(A_PIN));
  assign tgt_data = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      pincfg <= '0;
    end else begin
      if (ctrl_hit) ctrl   <= ctrl_t'(wdata[CW-1:0]);
      if (pin_hit)  pincfg <= pincfg_t'(wdata[PW-1:0]);
    end
  end

  genvar w;
  generate
    for (w = 0; w < NW; w++) begin : g_word
      logic [REG_W-1:0] per_word;
      logic             per_hit;
      assign per_hit   = wr && (addr == ADDR_W'(A_PER + w));
      assign tgt_wr[w] = wr && (addr == ADDR_W'(A_TGT + w));
      always_ff @(posedge clk) begin
        if (!rst_n)       per_word <= '0;
        else if (per_hit) per_word <= wdata;
      end
      assign period[w*REG_W +: REG_W] = per_word;
    end
  endgenerate

  // R2: a control write lands in the control word on the next cycle
  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> (ctrl == ctrl_t'($past(wdata[CW-1:0]))))
    else $error("control write not captured");

endmodule

// File: rtl/pps_sched.sv
module pps_sched
  import pps_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrl_t                    ctrl,
  input  stamp_t                   period,
  input  stamp_t                   sys_time,
  input  logic [STAMP_W/REG_W-1:0] tgt_wr,
  input  logic [REG_W-1:0]         tgt_data,
  output logic                     level,
  output logic                     fire
);

  localparam int unsigned NW = STAMP_W / REG_W;

  stamp_t target;
  logic   run_q;
  logic   start;
  logic   free_load;
  logic   sw_tgt;

  assign start     = ctrl.run & ~run_q;
  assign free_load = start & ~ctrl.align;
  assign sw_tgt    = |tgt_wr;
  assign fire      = ctrl.run & ~free_load & time_reached(sys_time, target);

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= ctrl.run;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target <= '0;
    end else if (sw_tgt) begin
      for (int i = 0; i < NW; i++)
        if (tgt_wr[i]) target[i*REG_W +: REG_W] <= tgt_data;
    end else if (free_load) begin
      target <= advance(sys_time, period);
    end else if (fire) begin
      target <= advance(target, period);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        level <= 1'b0;
    else if (!ctrl.run) level <= 1'b0;
    else if (fire)     level <= ~level;
  end

  // R3: every crossing flips the level
  p_flip_on_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (level != $past(level)))
    else $error("crossing without flip");

  // R4: an unclaimed crossing advances the target by the spacing
  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !sw_tgt) |=> (target == $past(target) + $past(period)))
    else $error("target not advanced by spacing");

  // R6: the free-start cycle never flips
  p_free_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    free_load |=> (level == $past(level)))
    else $error("flip on free start");

  // R7: a stopped generator is low on the next cycle
  p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |=> !level)
    else $error("level high while stopped");

endmodule

// File: rtl/pps_pin.sv
module pps_pin
  import pps_pkg::*;
(
  input  pincfg_t cfg,
  input  logic    level,
  output logic    pin_out,
  output logic    pin_oe
);

  assign pin_oe  = cfg.drive;
  assign pin_out = cfg.route ? level : cfg.fixed_lvl;

endmodule

// File: rtl/pps_pulse_gen.sv
module pps_pulse_gen #(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [pps_pkg::STAMP_W-1:0]  sys_time,
  input  logic                         reg_wr,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [REG_W-1:0]             reg_wdata,
  output logic                         pin_out,
  output logic                         pin_oe,
  output logic                         irq
);
  import pps_pkg::*;

  localparam int unsigned NW = STAMP_W / REG_W;

  ctrl_t            ctrl;
  stamp_t           period;
  pincfg_t          pincfg;
  logic [NW-1:0]    tgt_wr;
  logic [REG_W-1:0] tgt_data;
  logic             level;
  logic             fire;

  pps_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .ctrl     (ctrl),
    .period   (period),
    .pincfg   (pincfg),
    .tgt_wr   (tgt_wr),
    .tgt_data (tgt_data)
  );

  pps_sched #(.REG_W(REG_W)) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .period   (period),
    .sys_time (sys_time),
    .tgt_wr   (tgt_wr),
    .tgt_data (tgt_data),
    .level    (level),
    .fire     (fire)
  );

  pps_pin u_pin (
    .cfg     (pincfg),
    .level   (level),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= fire & ctrl.irq_en;
  end

  // R8: an interrupt cycle always sits right after a level flip
  p_irq_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (level != $past(level)))
    else $error("interrupt without flip");

endmodule

// File: tb/pps_pulse_gen_bench.sv
module pps_pulse_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_time = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        pin_out, pin_oe, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pps_pulse_gen u_pps_pulse_gen (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; the write lands on the following rising edge
  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // number of targets crossed by time t for first target tg and spacing p
  function automatic longint unsigned crossed(longint unsigned t, longint unsigned tg,
                                              longint unsigned p);
    return (t >= tg) ? ((t - tg) / p + 1) : 0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    step();
    chk("R1 pin_out after release", pin_out, 0);

    // sweep: aligned start, interrupt on, pin routed and driven
    for (int b = 0; b < 2; b++) begin
      for (int inc = 1; inc <= 3; inc++) begin
        for (int pi = 0; pi < 3; pi++) begin
          for (int ti = 0; ti < 3; ti++) begin
            longint unsigned base, per, tg, prev, c;
            base = (b == 0) ? 64'd0 : 64'h1_0000_0000;
            per  = (pi == 0) ? 3 : (pi == 1) ? 4 : 7;
            tg   = (ti == 0) ? 0 : (ti == 1) ? 5 : 11;
            wr(0, 0);
            wr(5, 32'h3);
            wr(1, 32'(per));
            wr(2, 0);
            wr(3, 32'(base + tg));
            wr(4, 32'((base + tg) >> 32));
            sys_time = base;
            step();
            chk("R7 idle low", pin_out, 0);
            chk("R9 oe driven", pin_oe, 1);
            wr(0, 7);
            prev = 0;
            for (int k = 0; k < 30; k++) begin
              sys_time = base + longint'(k * inc);
              step();
              c = crossed(longint'(k * inc), tg, per);
              chk("R3/R4 level", pin_out, c[0]);
              chk("R8 irq", irq, (c != prev) ? 1 : 0);
              prev = c;
            end
          end
        end
      end
    end

    // R5 catch-up after a forward jump
    wr(0, 0); wr(1, 4); wr(2, 0); wr(3, 10); wr(4, 0);
    sys_time = 0;
    wr(0, 7);
    step();
    chk("R5 before jump", pin_out, 0);
    sys_time = 30;
    for (int i = 1; i <= 6; i++) begin
      step();
      chk("R5 catch-up level", pin_out, i % 2);
      chk("R5 catch-up irq", irq, 1);
    end
    step();
    chk("R5 caught up level", pin_out, 0);
    chk("R5 caught up irq", irq, 0);

    // R6 free start: old target already passed, no flip at enable
    wr(0, 0); wr(1, 5); wr(2, 0); wr(3, 0); wr(4, 0);
    sys_time = 100;
    wr(0, 5);
    step();
    chk("R6 no flip at start", pin_out, 0);
    chk("R6 no irq at start", irq, 0);
    sys_time = 104; step();
    chk("R6 before first", pin_out, 0);
    sys_time = 105; step();
    chk("R6 first flip", pin_out, 1);
    chk("R6 first irq", irq, 1);
    sys_time = 109; step();
    chk("R6 hold", pin_out, 1);
    sys_time = 110; step();
    chk("R6 second flip", pin_out, 0);

    // R10 software target write beats the hardware advance
    wr(0, 0); wr(1, 4); wr(2, 0); wr(3, 10); wr(4, 0);
    sys_time = 5;
    wr(0, 7);
    step();
    chk("R10 before", pin_out, 0);
    sys_time = 12;
    wr(3, 50);
    chk("R10 flip on write cycle", pin_out, 1);
    sys_time = 20; step();
    chk("R10 stale advance ignored", pin_out, 1);
    sys_time = 50; step();
    chk("R10 written target used", pin_out, 0);

    // R7 stop: target now 54
    sys_time = 55; step();
    chk("R7 running flip", pin_out, 1);
    sys_time = 56;
    wr(0, 0);
    step();
    chk("R7 low after stop", pin_out, 0);
    sys_time = 1000;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R7 no flip when stopped", pin_out, 0);
      chk("R7 no irq when stopped", irq, 0);
    end

    // R8 interrupt disabled: flips happen, irq stays low
    wr(1, 3); wr(3, 0); wr(4, 0);
    sys_time = 0;
    wr(0, 3);
    for (int k = 0; k < 9; k++) begin
      longint unsigned c;
      sys_time = 64'(k);
      step();
      c = crossed(longint'(k), 0, 3);
      chk("R8 level with irq off", pin_out, c[0]);
      chk("R8 irq off", irq, 0);
    end

    // R9 pin setup and R2 unused addresses
    wr(0, 0);
    wr(5, 32'h5);
    chk("R9 fixed level out", pin_out, 1);
    chk("R9 fixed level oe", pin_oe, 1);
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'h0);
    chk("R2 ignored addr out", pin_out, 1);
    chk("R2 ignored addr oe", pin_oe, 1);
    wr(5, 32'h4);
    chk("R9 undriven oe", pin_oe, 0);
    chk("R9 undriven out", pin_out, 1);
    wr(5, 32'h0);
    chk("R9 cleared out", pin_out, 0);
    chk("R9 cleared oe", pin_oe, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule